// File: doc/BRIEF.md
# Eight-bit ALU with flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes an operation code, a register operand, a memory operand and the four current condition flags (carry, zero, overflow, negative). It returns a result byte, the updated flag vector, a per-flag write mask and a strobe that says whether the result should be written back. The surrounding pipeline uses the mask to merge the new flags into its status register. It uses the strobe to decide whether the destination register is written. Compare and bit test only inform the flags, so they leave the strobe low.

Arithmetic is always binary. Subtraction treats the incoming carry as "no borrow pending". Overflow is derived separately for add and subtract from the operand and result sign bits. A parameter selects whether the outputs are taken straight from the combinational logic or held in a stage of registers. The default holds them in registers, so every result appears one clock after its inputs.

Top module: `acc_alu_core`

## Requirements
- R1: Op code 0 (add) gives result = low byte of reg + mem + C. C out is set when the true sum exceeds 255. V is set when both operands share a sign bit and the result's sign bit differs from the register operand's.
- R2: Op code 1 (subtract) gives result = low byte of reg − mem − (1 − C). C out is 1 exactly when the true difference is not negative. V is set when the operands' sign bits differ and the result's sign bit differs from the register operand's.
- R3: Op codes 2, 3 and 4 (AND, OR, XOR) write the bitwise result and update only Z and N. V and C pass through unchanged.
- R4: Op code 5 shifts left with a zero entering bit 0 and bit 7 leaving into C. Op code 6 shifts right with a zero entering bit 7 and bit 0 leaving into C.
- R5: Op code 7 rotates left, with the old C entering bit 0 and bit 7 leaving into C. Op code 8 rotates right, with the old C entering bit 7 and bit 0 leaving into C.
- R6: Op code 9 (compare) makes no result write and outputs the register operand unchanged. It sets C when reg ≥ mem unsigned, sets Z when they are equal, and takes N from bit 7 of the 8-bit difference. V passes through.
- R7: Op code 10 (bit test) makes no result write and outputs the register operand unchanged. N takes mem bit 7, V takes mem bit 6, and Z is set when reg AND mem is zero. C passes through.
- R8: Flags are packed as bit 0 = C, bit 1 = Z, bit 2 = V, bit 3 = N. The write mask marks exactly the flags an operation affects: 1111 for add and subtract, 1010 for logic ops, 1011 for shifts, rotates and compare, 1110 for bit test. Any flag not marked equals its input value.
- R9: For every operation that writes a result, Z is set exactly when the result is zero and N equals result bit 7.
- R10: Op codes 11 to 15 have no effect. The result write strobe is low, the mask is zero, the flags equal their inputs and the result equals the register operand.
- R11: With the registered option (default), all outputs are zero during reset. Outputs change only on the rising clock edge that follows the inputs, and they hold the values computed from those inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_sel | input | 4 | Operation code |
| reg_opnd | input | 8 | Register operand |
| mem_opnd | input | 8 | Memory operand |
| flags_in | input | 4 | Current flags {N, V, Z, C} |
| result | output | 8 | Result byte |
| result_wr | output | 1 | High when the result is to be written back |
| flags_out | output | 4 | Updated flags {N, V, Z, C} |
| flag_wr | output | 4 | Per-flag write mask, same bit order as the flags |

## Verification
Every output is due on the first rising edge after its inputs are applied, because there is exactly one register stage between the inputs and the outputs. The bench changes inputs on the falling edge, then looks at the outputs shortly before the next rising edge to confirm they still show the previous operation. It compares them with its own model 1 ns after that edge. The bound checker registers the inputs once to line them up with the outputs. Its properties are enabled only from the second edge after reset, once the output stage holds a computed value rather than its reset value.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_SHL  = 4'd5,
      OP_SHR  = 4'd6,
      OP_ROL  = 4'd7,
      OP_ROR  = 4'd8,
      OP_CMP  = 4'd9,
      OP_BITT = 4'd10
   } alu_op_e;

   localparam int NFLAGS = 4;
   localparam int FL_C   = 0;
   localparam int FL_Z   = 1;
   localparam int FL_V   = 2;
   localparam int FL_N   = 3;

   localparam logic [NFLAGS-1:0] MASK_ARITH = 4'b1111;
   localparam logic [NFLAGS-1:0] MASK_LOGIC = 4'b1010;
   localparam logic [NFLAGS-1:0] MASK_SHIFT = 4'b1011;
   localparam logic [NFLAGS-1:0] MASK_BITT  = 4'b1110;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   total;

   // Subtraction adds the inverted operand; carry in then acts as "no borrow".
   assign b_eff = sub ? ~b : b;
   assign total = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
   assign sum   = total[MSB:0];
   assign cout  = total[WIDTH];
   assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic             cin,
   input  logic             right,
   input  logic             rotate,
   output logic [WIDTH-1:0] y,
   output logic             cout
);
   logic fill;

   always_comb begin
      fill = rotate ? cin : 1'b0;
      if (right) begin
         y    = {fill, a[WIDTH-1:1]};
         cout = a[0];
      end else begin
         y    = {a[WIDTH-2:0], fill};
         cout = a[WIDTH-1];
      end
   end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       kind,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      case (kind)
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = a & b;
      endcase
   end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          op_sel,
   input  logic [WIDTH-1:0]    reg_opnd,
   input  logic [WIDTH-1:0]    mem_opnd,
   input  logic [NFLAGS-1:0]   flags_in,
   output logic [WIDTH-1:0]    result,
   output logic                result_wr,
   output logic [NFLAGS-1:0]   flags_out,
   output logic [NFLAGS-1:0]   flag_wr
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("acc_alu_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0]  as_sum, sh_y, lg_y;
   logic              as_cout, as_ovf, sh_cout;
   logic              as_sub, as_cin, is_cmp;
   logic [1:0]        lg_kind;
   logic [WIDTH-1:0]  res_c;
   logic              rwr_c;
   logic [NFLAGS-1:0] fl_c, mask_c;

   // One adder serves add, subtract and compare.
   assign is_cmp  = (op_sel == OP_CMP);
   assign as_sub  = (op_sel == OP_SUB) || is_cmp;
   assign as_cin  = is_cmp ? 1'b1 : flags_in[FL_C];
   assign lg_kind = (op_sel == OP_OR)  ? 2'd1 :
                    (op_sel == OP_XOR) ? 2'd2 : 2'd0;

   acc_alu_addsub #(.WIDTH(WIDTH)) addsub_i (
      .a(reg_opnd), .b(mem_opnd), .cin(as_cin), .sub(as_sub),
      .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
   );

   acc_alu_shift #(.WIDTH(WIDTH)) shift_i (
      .a(reg_opnd), .cin(flags_in[FL_C]),
      .right((op_sel == OP_SHR) || (op_sel == OP_ROR)),
      .rotate((op_sel == OP_ROL) || (op_sel == OP_ROR)),
      .y(sh_y), .cout(sh_cout)
   );

   acc_alu_logic #(.WIDTH(WIDTH)) logic_i (
      .a(reg_opnd), .b(mem_opnd), .kind(lg_kind), .y(lg_y)
   );

   always_comb begin
      res_c  = reg_opnd;
      fl_c   = flags_in;
      mask_c = '0;
      rwr_c  = 1'b0;
      case (op_sel)
         OP_ADD, OP_SUB: begin
            res_c      = as_sum;
            fl_c[FL_C] = as_cout;
            fl_c[FL_V] = as_ovf;
            mask_c     = MASK_ARITH;
            rwr_c      = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_c  = lg_y;
            mask_c = MASK_LOGIC;
            rwr_c  = 1'b1;
         end
         OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
            res_c      = sh_y;
            fl_c[FL_C] = sh_cout;
            mask_c     = MASK_SHIFT;
            rwr_c      = 1'b1;
         end
         OP_CMP: begin
            fl_c[FL_C] = as_cout;
            fl_c[FL_Z] = (as_sum == '0);
            fl_c[FL_N] = as_sum[MSB];
            mask_c     = MASK_SHIFT;
         end
         OP_BITT: begin
            fl_c[FL_N] = mem_opnd[MSB];
            fl_c[FL_V] = mem_opnd[MSB-1];
            fl_c[FL_Z] = ((reg_opnd & mem_opnd) == '0);
            mask_c     = MASK_BITT;
         end
         default: ;
      endcase
      if (rwr_c) begin
         fl_c[FL_Z] = (res_c == '0);
         fl_c[FL_N] = res_c[MSB];
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result    <= '0;
            result_wr <= 1'b0;
            flags_out <= '0;
            flag_wr   <= '0;
         end else begin
            result    <= res_c;
            result_wr <= rwr_c;
            flags_out <= fl_c;
            flag_wr   <= mask_c;
         end
      end
   end else begin : g_comb
      assign result    = res_c;
      assign result_wr = rwr_c;
      assign flags_out = fl_c;
      assign flag_wr   = mask_c;
   end
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk
   import acc_alu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [3:0]          op_sel,
   input logic [WIDTH-1:0]    reg_opnd,
   input logic [WIDTH-1:0]    mem_opnd,
   input logic [NFLAGS-1:0]   flags_in,
   input logic [WIDTH-1:0]    result,
   input logic                result_wr,
   input logic [NFLAGS-1:0]   flags_out,
   input logic [NFLAGS-1:0]   flag_wr
);
   logic [3:0]        p_op;
   logic [WIDTH-1:0]  p_reg, p_mem;
   logic [NFLAGS-1:0] p_fl;
   logic              armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   if (REG_OUT) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_op <= '0; p_reg <= '0; p_mem <= '0; p_fl <= '0;
         end else begin
            p_op <= op_sel; p_reg <= reg_opnd; p_mem <= mem_opnd; p_fl <= flags_in;
         end
      end
   end else begin : g_direct
      assign p_op  = op_sel;
      assign p_reg = reg_opnd;
      assign p_mem = mem_opnd;
      assign p_fl  = flags_in;
   end

   // R1
   add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_op == OP_ADD) |->
         {flags_out[FL_C], result} == ({1'b0, p_reg} + {1'b0, p_mem} + {{WIDTH{1'b0}}, p_fl[FL_C]}));

   // R6
   cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_op == OP_CMP) |->
         (!result_wr && result == p_reg && flags_out[FL_C] == (p_reg >= p_mem)));

   // R7
   bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_op == OP_BITT) |->
         (!result_wr && flags_out[FL_N] == p_mem[WIDTH-1] && flags_out[FL_V] == p_mem[WIDTH-2]));

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (((flags_out ^ p_fl) & ~flag_wr) == '0));

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && result_wr) |-> (flags_out[FL_Z] == (result == '0) && flags_out[FL_N] == result[WIDTH-1]));

   // R10
   idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && p_op > 4'd10) |-> (!result_wr && flag_wr == '0 && result == p_reg));
endmodule

bind acc_alu_core acc_alu_core_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (
   .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .reg_opnd(reg_opnd),
   .mem_opnd(mem_opnd), .flags_in(flags_in), .result(result),
   .result_wr(result_wr), .flags_out(flags_out), .flag_wr(flag_wr)
);

// File: tb/acc_alu_core_tb_top.sv
`timescale 1ns/1ps
module acc_alu_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_sel = '0;
   logic [7:0] reg_opnd = '0, mem_opnd = '0;
   logic [3:0] flags_in = '0;
   logic [7:0] result;
   logic       result_wr;
   logic [3:0] flags_out, flag_wr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   acc_alu_core dut_i (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .reg_opnd(reg_opnd),
      .mem_opnd(mem_opnd), .flags_in(flags_in), .result(result),
      .result_wr(result_wr), .flags_out(flags_out), .flag_wr(flag_wr)
   );

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2, 4'd3, 4'd4: return "R3";
         4'd5, 4'd6: return "R4";
         4'd7, 4'd8: return "R5";
         4'd9: return "R6";
         4'd10: return "R7";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [7:0] pick(input int i);
      case (i)
         16: return 8'h7F;
         17: return 8'h80;
         18: return 8'h01;
         19: return 8'hFE;
         default: return 8'(i * 17);
      endcase
   endfunction

   task automatic model(input logic [3:0] op, input logic [7:0] a, m, input logic [3:0] fi,
                        output logic [7:0] r, output logic [3:0] f, output logic [3:0] mk,
                        output logic rw);
      int s;
      logic [7:0] d;
      r = a; f = fi; mk = 4'b0000; rw = 1'b0;
      case (op)
         4'd0: begin
            s = int'(a) + int'(m) + int'(fi[0]);
            r = 8'(s); f[0] = (s > 255); f[2] = (a[7] == m[7]) && (r[7] != a[7]);
            mk = 4'b1111; rw = 1'b1;
         end
         4'd1: begin
            s = int'(a) - int'(m) - (1 - int'(fi[0]));
            r = 8'(s); f[0] = (s >= 0); f[2] = (a[7] != m[7]) && (r[7] != a[7]);
            mk = 4'b1111; rw = 1'b1;
         end
         4'd2: begin r = a & m; mk = 4'b1010; rw = 1'b1; end
         4'd3: begin r = a | m; mk = 4'b1010; rw = 1'b1; end
         4'd4: begin r = a ^ m; mk = 4'b1010; rw = 1'b1; end
         4'd5: begin r = {a[6:0], 1'b0};  f[0] = a[7]; mk = 4'b1011; rw = 1'b1; end
         4'd6: begin r = {1'b0, a[7:1]};  f[0] = a[0]; mk = 4'b1011; rw = 1'b1; end
         4'd7: begin r = {a[6:0], fi[0]}; f[0] = a[7]; mk = 4'b1011; rw = 1'b1; end
         4'd8: begin r = {fi[0], a[7:1]}; f[0] = a[0]; mk = 4'b1011; rw = 1'b1; end
         4'd9: begin
            d = a - m;
            f[0] = (a >= m); f[1] = (a == m); f[3] = d[7]; mk = 4'b1011;
         end
         4'd10: begin
            f[3] = m[7]; f[2] = m[6]; f[1] = ((a & m) == 8'h00); mk = 4'b1110;
         end
         default: ;
      endcase
      if (rw) begin
         f[1] = (r == 8'h00);
         f[3] = r[7];
      end
   endtask

   task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (op %0d reg %h mem %h flags %b)",
                  tag, what, act, exp, op_sel, reg_opnd, mem_opnd, flags_in);
      end
   endtask

   initial begin
      logic [7:0] er, pr;
      logic [3:0] ef, em, pf, pm;
      logic       ew, pw;
      logic [3:0] fpat [4];
      fpat[0] = 4'b0000; fpat[1] = 4'b1111; fpat[2] = 4'b0101; fpat[3] = 4'b1010;

      // R11: reset state
      op_sel = 4'd0; reg_opnd = 8'hFF; mem_opnd = 8'h01; flags_in = 4'b1111;
      repeat (3) @(posedge clk);
      #1;
      check("R11", "reset result", result, 8'h00);
      check("R11", "reset flags", {4'h0, flags_out}, 8'h00);
      check("R11", "reset mask", {4'h0, flag_wr}, 8'h00);
      check("R11", "reset write", {7'h0, result_wr}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      pr = 8'h00; pf = 4'h0; pm = 4'h0; pw = 1'b0;
      for (int op = 0; op < 16; op++) begin
         for (int ia = 0; ia < 20; ia++) begin
            for (int im = 0; im < 20; im++) begin
               for (int fp = 0; fp < 4; fp++) begin
                  @(negedge clk);
                  op_sel = 4'(op); reg_opnd = pick(ia); mem_opnd = pick(im); flags_in = fpat[fp];
                  model(op_sel, reg_opnd, mem_opnd, flags_in, er, ef, em, ew);
                  #1;
                  // R11: outputs hold until the next rising edge
                  if (op == 3 && fp == 0) begin
                     check("R11", "held result", result, pr);
                     check("R11", "held flags", {4'h0, flags_out}, {4'h0, pf});
                  end
                  @(posedge clk);
                  #1;
                  check(tag_of(op_sel), "result", result, er);
                  check(tag_of(op_sel), "flags", {4'h0, flags_out}, {4'h0, ef});
                  check(tag_of(op_sel), "write", {7'h0, result_wr}, {7'h0, ew});
                  // R8: mask and untouched flags
                  check("R8", "mask", {4'h0, flag_wr}, {4'h0, em});
                  check("R8", "held flags", {4'h0, flags_out & ~flag_wr}, {4'h0, flags_in & ~em});
                  if (ew) begin
                     // R9: Z and N follow the written result
                     check("R9", "zn", {6'h0, flags_out[3], flags_out[1]},
                           {6'h0, er[7], (er == 8'h00)});
                  end
                  pr = er; pf = ef; pm = em; pw = ew;
               end
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule